// File: doc/BRIEF.md
# Recovery Register Read Reply Formatter

This block builds the target's answer to a register read made on the recovery virtual address. The command handler first receives the request: a command byte and its checksum, then a repeated start and a private read. It then hands this block the register contents, the register's length and whether the request checksum matched. The block frames the reply and feeds it, one byte per handshake, into the core's transmit queue. A reply is the 16-bit length, low byte first, then the register bytes, then a CRC-8 check byte.

A select input marks whether recovery mode is active. When it is not, a transmit multiplexer passes the core's own outgoing traffic to the queue unchanged, and the formatter accepts no requests. When recovery mode is active, the core's own traffic is held back and only framed replies reach the queue. The checksum engine is cleared at the start of every reply. If the initiator ends the read early, the bus side signals an abort and the block drops back to idle.

Top module: `recov_rd_tx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tx_valid_o` is 0. With recovery mode selected, `req_ready_o` is 1 once reset is released.
- R2: With `recov_en_i` at 0, `tx_valid_o` and `tx_data_o` follow `core_tx_valid_i` and `core_tx_data_i`, `core_tx_ready_o` follows `tx_ready_i`, and `req_ready_o` is 0, so no request is taken.
- R3: With `recov_en_i` at 1, `core_tx_ready_o` is 0 and the core's traffic does not reach the queue.
- R4: A request accepted with `req_pec_ok_i` at 1 puts a reply on the queue from the next cycle. The reply is: length bits 7:0, length bits 15:8, then the data bytes starting from `req_data_i[7:0]` in ascending byte order, then one check byte.
- R5: The check byte is a CRC-8 with polynomial 0x07 (x^8+x^2+x+1), initial value 0x00, no reflection and no final XOR, processed MSB first. It is computed over both length bytes and all data bytes.
- R6: The checksum starts from 0x00 for every reply, so back-to-back replies do not affect each other.
- R7: A length of 0 gives a three-byte reply: 0x00, 0x00 and the check byte.
- R8: A requested length above MAX_BYTES (default 16) is clamped to MAX_BYTES, both in the length prefix and in the number of data bytes sent.
- R9: A request accepted with `req_pec_ok_i` at 0 produces no reply bytes, and the block stays ready for the next request.
- R10: A pulse on `rd_abort_i` ends any reply in progress. From the next cycle `tx_valid_o` is 0 and `req_ready_o` is 1. Abort has priority over accepting a request in the same cycle.
- R11: While `tx_valid_o` is 1 and `tx_ready_i` is 0, the offered byte stays the same and remains valid.
- R12: `req_ready_o` is 1 only when recovery mode is selected and no reply is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| recov_en_i | input | 1 | Recovery mode select |
| req_valid_i | input | 1 | Read request from the command handler |
| req_ready_o | output | 1 | Formatter idle and able to take a request |
| req_pec_ok_i | input | 1 | Checksum of the read request matched |
| req_len_i | input | 16 | Register length in bytes |
| req_data_i | input | MAX_BYTES*8 | Register contents, byte 0 in the low bits |
| rd_abort_i | input | 1 | Initiator ended the private read early |
| core_tx_valid_i | input | 1 | Core's own transmit byte valid |
| core_tx_data_i | input | 8 | Core's own transmit byte |
| core_tx_ready_o | output | 1 | Queue accepted the core's byte |
| tx_valid_o | output | 1 | Byte offered to the transmit queue |
| tx_data_o | output | 8 | Byte to the transmit queue |
| tx_ready_i | input | 1 | Transmit queue takes the byte |

## Verification
The framing is tried with a four-byte register, a zero-length register, an over-long length that must be clamped, and two different replies sent back to back. Together these separate a wrong byte order, a missing or extra data byte, a length prefix that is not clamped, and a checksum that is not cleared between replies. One reply is sent with the queue stalling on every byte, to show that bytes are held and not skipped or repeated. Requests with a bad checksum, early aborts and traffic with recovery mode off show that nothing leaks onto the queue in those cases and that the core's traffic is switched correctly.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

    localparam int LEN_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN_LO,
        ST_LEN_HI,
        ST_DATA,
        ST_PEC
    } rrt_state_e;

    // One byte through an MSB-first CRC-8 with the given polynomial
    function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                             input logic [7:0] din,
                                             input logic [7:0] poly);
        logic [7:0] c;
        c = crc ^ din;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ poly) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/rrt_crc8.sv
module rrt_crc8 #(
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'h00
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       clear_i,
    input  logic       upd_i,
    input  logic [7:0] byte_i,
    output logic [7:0] crc_o
);
    import rrt_pkg::*;

    logic [7:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear_i) begin
            crc_d = INIT;
        end else if (upd_i) begin
            crc_d = crc8_step(crc_q, byte_i, POLY);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) crc_q <= INIT;
        else         crc_q <= crc_d;
    end

    assign crc_o = crc_q;

endmodule

// File: rtl/rrt_seq.sv
module rrt_seq #(
    parameter int MAX_BYTES = 16
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   en_i,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic                   req_pec_ok_i,
    input  logic [15:0]            req_len_i,
    input  logic [MAX_BYTES*8-1:0] req_data_i,
    input  logic                   abort_i,
    output logic                   rsp_valid_o,
    output logic [7:0]             rsp_byte_o,
    input  logic                   rsp_ready_i,
    output logic                   crc_clr_o,
    output logic                   crc_upd_o,
    input  logic [7:0]             crc_i
);
    import rrt_pkg::*;

    localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BYTES);

    typedef struct packed {
        rrt_state_e             state;
        logic [LEN_W-1:0]       len;
        logic [MAX_BYTES*8-1:0] data;
        logic [IDX_W-1:0]       idx;
    } seq_t;

    seq_t s_d, s_q;
    logic [LEN_W-1:0] len_eff;
    logic             take;
    logic             last_data;

    always_comb begin
        s_d         = s_q;
        rsp_valid_o = 1'b0;
        rsp_byte_o  = 8'h00;
        crc_clr_o   = 1'b0;
        req_ready_o = en_i && (s_q.state == ST_IDLE);
        len_eff     = (req_len_i > MAX_LEN) ? MAX_LEN : req_len_i;
        take        = 1'b0;
        last_data   = ({{(LEN_W-IDX_W){1'b0}}, s_q.idx} == (s_q.len - 1'b1));

        unique case (s_q.state)
            ST_IDLE: begin
                if (req_valid_i && req_ready_o && req_pec_ok_i) begin
                    s_d.state = ST_LEN_LO;
                    s_d.len   = len_eff;
                    s_d.data  = req_data_i;
                    s_d.idx   = '0;
                    crc_clr_o = 1'b1;
                end
            end
            ST_LEN_LO: begin
                rsp_valid_o = 1'b1;
                rsp_byte_o  = s_q.len[7:0];
                take        = rsp_ready_i;
                if (take) s_d.state = ST_LEN_HI;
            end
            ST_LEN_HI: begin
                rsp_valid_o = 1'b1;
                rsp_byte_o  = s_q.len[15:8];
                take        = rsp_ready_i;
                if (take) s_d.state = (s_q.len == '0) ? ST_PEC : ST_DATA;
            end
            ST_DATA: begin
                rsp_valid_o = 1'b1;
                rsp_byte_o  = s_q.data[s_q.idx*8 +: 8];
                take        = rsp_ready_i;
                if (take) begin
                    if (last_data) s_d.state = ST_PEC;
                    else           s_d.idx   = s_q.idx + 1'b1;
                end
            end
            ST_PEC: begin
                rsp_valid_o = 1'b1;
                rsp_byte_o  = crc_i;
                if (rsp_ready_i) s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase

        crc_upd_o = take;

        if (abort_i || !en_i) begin
            s_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.state <= ST_IDLE;
            s_q.len   <= '0;
            s_q.data  <= '0;
            s_q.idx   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/rrt_txmux.sv
module rrt_txmux (
    input  logic       sel_rsp_i,
    input  logic       rsp_valid_i,
    input  logic [7:0] rsp_byte_i,
    output logic       rsp_ready_o,
    input  logic       core_valid_i,
    input  logic [7:0] core_byte_i,
    output logic       core_ready_o,
    output logic       q_valid_o,
    output logic [7:0] q_byte_o,
    input  logic       q_ready_i
);
    always_comb begin
        if (sel_rsp_i) begin
            q_valid_o    = rsp_valid_i;
            q_byte_o     = rsp_byte_i;
            rsp_ready_o  = q_ready_i;
            core_ready_o = 1'b0;
        end else begin
            q_valid_o    = core_valid_i;
            q_byte_o     = core_byte_i;
            rsp_ready_o  = 1'b0;
            core_ready_o = q_ready_i;
        end
    end
endmodule

// File: rtl/recov_rd_tx.sv
module recov_rd_tx #(
    parameter int         MAX_BYTES = 16,
    parameter logic [7:0] CRC_POLY  = 8'h07
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   recov_en_i,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic                   req_pec_ok_i,
    input  logic [15:0]            req_len_i,
    input  logic [MAX_BYTES*8-1:0] req_data_i,
    input  logic                   rd_abort_i,
    input  logic                   core_tx_valid_i,
    input  logic [7:0]             core_tx_data_i,
    output logic                   core_tx_ready_o,
    output logic                   tx_valid_o,
    output logic [7:0]             tx_data_o,
    input  logic                   tx_ready_i
);
    logic       rsp_valid;
    logic [7:0] rsp_byte;
    logic       rsp_ready;
    logic       crc_clr;
    logic       crc_upd;
    logic [7:0] crc_val;

    rrt_seq #(.MAX_BYTES(MAX_BYTES)) seq_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .en_i         (recov_en_i),
        .req_valid_i  (req_valid_i),
        .req_ready_o  (req_ready_o),
        .req_pec_ok_i (req_pec_ok_i),
        .req_len_i    (req_len_i),
        .req_data_i   (req_data_i),
        .abort_i      (rd_abort_i),
        .rsp_valid_o  (rsp_valid),
        .rsp_byte_o   (rsp_byte),
        .rsp_ready_i  (rsp_ready),
        .crc_clr_o    (crc_clr),
        .crc_upd_o    (crc_upd),
        .crc_i        (crc_val)
    );

    rrt_crc8 #(.POLY(CRC_POLY), .INIT(8'h00)) crc_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (crc_clr),
        .upd_i   (crc_upd),
        .byte_i  (rsp_byte),
        .crc_o   (crc_val)
    );

    rrt_txmux mux_i (
        .sel_rsp_i    (recov_en_i),
        .rsp_valid_i  (rsp_valid),
        .rsp_byte_i   (rsp_byte),
        .rsp_ready_o  (rsp_ready),
        .core_valid_i (core_tx_valid_i),
        .core_byte_i  (core_tx_data_i),
        .core_ready_o (core_tx_ready_o),
        .q_valid_o    (tx_valid_o),
        .q_byte_o     (tx_data_o),
        .q_ready_i    (tx_ready_i)
    );

endmodule

// File: rtl/recov_rd_tx_chk.sv
module recov_rd_tx_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       recov_en_i,
    input logic       req_valid_i,
    input logic       req_ready_o,
    input logic       req_pec_ok_i,
    input logic       rd_abort_i,
    input logic       core_tx_ready_o,
    input logic       tx_valid_o,
    input logic [7:0] tx_data_o,
    input logic       tx_ready_i
);
    // R3
    core_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        recov_en_i |-> !core_tx_ready_o);

    // R12
    ready_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (recov_en_i && req_ready_o) |-> !tx_valid_o);

    // R4
    reply_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (recov_en_i && req_valid_i && req_ready_o && req_pec_ok_i && !rd_abort_i)
        |=> (!recov_en_i || tx_valid_o));

    // R9
    bad_pec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (recov_en_i && req_valid_i && req_ready_o && !req_pec_ok_i)
        |=> (!recov_en_i || !tx_valid_o));

    // R10
    abort_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (recov_en_i && rd_abort_i) |=> (!recov_en_i || (!tx_valid_o && req_ready_o)));

    // R11
    hold_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (recov_en_i && tx_valid_o && !tx_ready_i && !rd_abort_i)
        |=> (!recov_en_i || (tx_valid_o && $stable(tx_data_o))));
endmodule

bind recov_rd_tx recov_rd_tx_chk chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .recov_en_i      (recov_en_i),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_pec_ok_i    (req_pec_ok_i),
    .rd_abort_i      (rd_abort_i),
    .core_tx_ready_o (core_tx_ready_o),
    .tx_valid_o      (tx_valid_o),
    .tx_data_o       (tx_data_o),
    .tx_ready_i      (tx_ready_i)
);

// File: tb/recov_rd_tx_tb.sv
module recov_rd_tx_tb_top;
    localparam int MAXB = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              recov_en = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_pec_ok = 1'b1;
    logic [15:0]       req_len = '0;
    logic [MAXB*8-1:0] req_data = '0;
    logic              rd_abort = 1'b0;
    logic              core_valid = 1'b0;
    logic [7:0]        core_data = '0;
    logic              core_ready;
    logic              tx_valid;
    logic [7:0]        tx_data;
    logic              tx_ready = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] exp_b [MAXB+3];
    int         exp_n;

    always #4 clk = ~clk;

    recov_rd_tx #(.MAX_BYTES(MAXB)) dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .recov_en_i      (recov_en),
        .req_valid_i     (req_valid),
        .req_ready_o     (req_ready),
        .req_pec_ok_i    (req_pec_ok),
        .req_len_i       (req_len),
        .req_data_i      (req_data),
        .rd_abort_i      (rd_abort),
        .core_tx_valid_i (core_valid),
        .core_tx_data_i  (core_data),
        .core_tx_ready_o (core_ready),
        .tx_valid_o      (tx_valid),
        .tx_data_o       (tx_data),
        .tx_ready_i      (tx_ready)
    );

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            fb = r[7] ^ b[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ 8'h07;
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic build_exp(input int ln, input logic [MAXB*8-1:0] d);
        int eff;
        logic [7:0] c;
        eff = (ln > MAXB) ? MAXB : ln;
        exp_b[0] = eff[7:0];
        exp_b[1] = eff[15:8];
        for (int k = 0; k < eff; k++) exp_b[2+k] = d[k*8 +: 8];
        c = 8'h00;
        for (int k = 0; k < eff + 2; k++) c = ref_crc(c, exp_b[k]);
        exp_b[eff+2] = c;
        exp_n = eff + 3;
    endtask

    task automatic send_req(input int ln, input logic [MAXB*8-1:0] d, input bit ok);
        @(negedge clk);
        req_valid  = 1'b1;
        req_len    = 16'(ln);
        req_data   = d;
        req_pec_ok = ok;
        @(negedge clk);
        req_valid  = 1'b0;
    endtask

    task automatic collect(input string req, input bit stall);
        for (int i = 0; i < exp_n; i++) begin
            chk(tx_valid === 1'b1, req, tx_valid, 1);
            chk(tx_data === exp_b[i], req, tx_data, exp_b[i]);
            if (stall) begin
                tx_ready = 1'b0;
                @(negedge clk);
                chk(tx_valid === 1'b1 && tx_data === exp_b[i], "R11", tx_data, exp_b[i]);
                tx_ready = 1'b1;
            end
            @(negedge clk);
        end
        chk(tx_valid === 1'b0, req, tx_valid, 0);
        chk(req_ready === 1'b1, req, req_ready, 1);
    endtask

    task automatic t_reset;
        chk(tx_valid === 1'b0, "R1", tx_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        chk(tx_valid === 1'b0, "R1", tx_valid, 0);
        @(negedge clk);
        chk(tx_valid === 1'b0, "R1", tx_valid, 0);
        chk(req_ready === 1'b1, "R1", req_ready, 1);
    endtask

    task automatic t_bypass;
        @(negedge clk);
        recov_en   = 1'b0;
        core_valid = 1'b1;
        core_data  = 8'hA5;
        tx_ready   = 1'b0;
        req_valid  = 1'b1;
        #1;
        chk(tx_valid === 1'b1 && tx_data === 8'hA5, "R2", tx_data, 8'hA5);
        chk(core_ready === 1'b0, "R2", core_ready, 0);
        chk(req_ready === 1'b0, "R2 R12", req_ready, 0);
        tx_ready = 1'b1;
        #1;
        chk(core_ready === 1'b1, "R2", core_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        recov_en  = 1'b1;
        #1;
        // R3: core traffic held back in recovery mode
        chk(core_ready === 1'b0, "R3", core_ready, 0);
        chk(tx_valid === 1'b0, "R3", tx_valid, 0);
        core_valid = 1'b0;
        @(negedge clk);
        chk(tx_valid === 1'b0, "R2 no request taken", tx_valid, 0);
    endtask

    task automatic t_basic;
        build_exp(4, 128'h0000_0000_0000_0000_0000_0000_DEAD_BEEF);
        send_req(4, 128'h0000_0000_0000_0000_0000_0000_DEAD_BEEF, 1'b1);
        collect("R4 R5", 1'b0);
    endtask

    task automatic t_zero;
        build_exp(0, '1);
        chk(exp_n == 3, "R7", exp_n, 3);
        send_req(0, '1, 1'b1);
        collect("R7", 1'b0);
    endtask

    task automatic t_clamp;
        logic [MAXB*8-1:0] d;
        for (int k = 0; k < MAXB; k++) d[k*8 +: 8] = 8'(8'h10 + k);
        build_exp(300, d);
        send_req(300, d, 1'b1);
        collect("R8", 1'b0);
    endtask

    task automatic t_stall;
        build_exp(3, 128'h0000_0000_0000_0000_0000_0000_0055_AA01);
        send_req(3, 128'h0000_0000_0000_0000_0000_0000_0055_AA01, 1'b1);
        collect("R11", 1'b1);
    endtask

    task automatic t_pec_fail;
        send_req(5, 128'h1234_5678, 1'b0);
        chk(tx_valid === 1'b0, "R9", tx_valid, 0);
        chk(req_ready === 1'b1, "R9", req_ready, 1);
        repeat (3) @(negedge clk);
        chk(tx_valid === 1'b0, "R9", tx_valid, 0);
    endtask

    task automatic t_abort;
        send_req(8, 128'h0102_0304_0506_0708, 1'b1);
        repeat (3) @(negedge clk);
        chk(tx_valid === 1'b1, "R10 mid reply", tx_valid, 1);
        rd_abort = 1'b1;
        @(negedge clk);
        rd_abort = 1'b0;
        chk(tx_valid === 1'b0, "R10", tx_valid, 0);
        chk(req_ready === 1'b1, "R10", req_ready, 1);
        // R10: abort wins over a request in the same cycle
        req_valid  = 1'b1;
        req_len    = 16'd2;
        req_pec_ok = 1'b1;
        rd_abort   = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        rd_abort  = 1'b0;
        chk(tx_valid === 1'b0, "R10 priority", tx_valid, 0);
        build_exp(2, 128'h00C3);
        send_req(2, 128'h00C3, 1'b1);
        collect("R10 R6 after abort", 1'b0);
    endtask

    task automatic t_b2b;
        build_exp(2, 128'h7F80);
        send_req(2, 128'h7F80, 1'b1);
        collect("R6 first", 1'b0);
        build_exp(1, 128'h0042);
        send_req(1, 128'h0042, 1'b1);
        collect("R6 second", 1'b0);
    endtask

    initial begin
        t_reset();
        t_bypass();
        t_basic();
        t_zero();
        t_clamp();
        t_stall();
        t_pec_fail();
        t_abort();
        t_b2b();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule